// File: doc/BRIEF.md
# Dual-Port Two-Way Level-1 Data Cache

This block is a small level-1 data cache that sits between a processor with two data ports and a larger, slower level-2 memory. In one cycle each port can issue a 32-bit load or store. When every load in that cycle hits, both ports complete in that cycle and the loaded words appear combinationally on their read buses. Storage is two-way set associative. Each set has one least-recently-used bit, and that bit names the way to evict on the next refill.

A load miss raises a shared stall. The cache then fetches the whole line from the next level over a request/response pair and writes it into the victim way. The stalled access is then evaluated again, and it completes once every load in the cycle hits. Stores write through and do not allocate. A store hit updates the cached word, and every store is forwarded on its port's write channel when it completes. When two ports meet in the same set, the cache behaves as if port 0 acted first and port 1 second. A flush input drops every line at once.

Top module: `dcache_dual`

## Requirements
- R1: When all requesting ports hit, `stall_o` is low in that cycle. Each loading port's `rdata_o` carries the addressed word. Both ports complete at the next clock edge and no refill is requested.
- R2: A load miss raises `stall_o` in the cycle of the request. The cache asks for the line by holding `fill_req_o` high with a stable line-aligned `fill_addr_o` until `fill_valid_i`. Word i of `fill_data_i` is bits [32i+31:32i]. The line is written when `fill_valid_i` is sampled, and the load then returns the correct word.
- R3: When both ports load-miss on different lines, port 0's line is fetched first and port 1's second, and `stall_o` stays high throughout. When both ports miss on the same line, exactly one refill is made.
- R4: With defaults of 4096 bytes, 32-byte lines and 2 ways, address bits [4:0] are the line offset, [10:5] the set and [31:11] the tag. Two lines with the same set and different tags can be resident together. At most one way hits per port.
- R5: A refill goes into the least-recently-used way of its set. Completed hits and refills make their way the most recent.
- R6: Same-set accesses in one cycle update recency as port 0 first, then port 1. While port 1 misses, the way port 0 hits in that set is never chosen as victim.
- R7: A completing store that hits writes its word in the cache. The same store is forwarded on `wr_o`/`wr_addr_o`/`wr_data_o` of its port.
- R8: A completing store that misses is forwarded and causes no refill and no allocation. A later load of that address misses and returns the stored value from the next level.
- R9: Loads in a cycle see the contents from before that cycle's stores. When both ports store to the same word in one cycle, port 1's value is the one the cache keeps.
- R10: A `flush_i` pulse invalidates every line at the next edge, so each later load misses once.
- R11: After reset `stall_o`, `fill_req_o` and `wr_o` are low while no port requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| req_i | input | 2 | Per-port access request |
| we_i | input | 2 | Per-port store (1) or load (0) |
| addr_i | input | 2x32 | Per-port byte address |
| wdata_i | input | 2x32 | Per-port store data |
| rdata_o | output | 2x32 | Per-port load data, valid when stall_o is low |
| stall_o | output | 1 | Hold all requests; no access completes |
| fill_req_o | output | 1 | Line refill request |
| fill_addr_o | output | 32 | Line-aligned refill address |
| fill_valid_i | input | 1 | Refill data valid |
| fill_data_i | input | 256 | Refill line data |
| wr_o | output | 2 | Per-port forwarded store strobe |
| wr_addr_o | output | 2x32 | Forwarded store address |
| wr_data_o | output | 2x32 | Forwarded store data |

## Verification
A bad tag, valid or recency bit inside the cache cannot be seen at once. It shows up on the very next access to the affected set, as an extra or missing refill request or as a wrong word on a read bus. The bench therefore runs its own model of tags, valid bits and recency next to the design. For every access it predicts the exact number of refills and the returned words. After each store it compares the next-level memory image with its own, so that a lost forwarded write appears one access later.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_WAYS  = 2;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_WAIT = 1'b1
  } fill_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
  import dcache_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 21,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 flush_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]      lk_idx_i,
  input  logic [NUM_PORTS-1:0][TAG_W-1:0]      lk_tag_i,
  output logic [NUM_PORTS-1:0][NUM_WAYS-1:0]   hit_way_o,
  input  logic                                 refill_i,
  input  logic [IDX_W-1:0]                     refill_idx_i,
  input  logic [TAG_W-1:0]                     refill_tag_i,
  input  logic                                 refill_way_i
);
  logic [SETS-1:0]  valid_q [NUM_WAYS];
  logic [TAG_W-1:0] tag_q   [NUM_WAYS][SETS];

  // flush wins over a same-cycle refill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q[0] <= '0;
      valid_q[1] <= '0;
    end else begin
      if (refill_i) valid_q[refill_way_i][refill_idx_i] <= 1'b1;
      if (flush_i) begin
        valid_q[0] <= '0;
        valid_q[1] <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (refill_i) tag_q[refill_way_i][refill_idx_i] <= refill_tag_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign hit_way_o[p][w] = valid_q[w][lk_idx_i[p]] &&
                               (tag_q[w][lk_idx_i[p]] == lk_tag_i[p]);
    end
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q[0] == '0 && valid_q[1] == '0))
    else $error("flush left a valid line"); // R10
endmodule

// File: rtl/dcache_lru.sv
module dcache_lru
  import dcache_pkg::*;
#(
  parameter int unsigned SETS = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PORTS-1:0]            upd_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] upd_idx_i,
  input  logic [NUM_PORTS-1:0]            upd_way_i,
  input  logic                            refill_i,
  input  logic [IDX_W-1:0]                refill_idx_i,
  input  logic                            refill_way_i,
  input  logic [IDX_W-1:0]                vic_idx_i,
  output logic                            victim_o
);
  // bit per set = way to evict next
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
    end else begin
      if (refill_i) lru_q[refill_idx_i] <= ~refill_way_i;
      // later port overrides: port 0 then port 1
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (upd_i[p]) lru_q[upd_idx_i[p]] <= ~upd_way_i[p];
      end
    end
  end

  assign victim_o = lru_q[vic_idx_i];

  logic             ord_pend_q;
  logic [IDX_W-1:0] ord_idx_q;
  logic             ord_way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_pend_q <= 1'b0;
      ord_idx_q  <= '0;
      ord_way_q  <= 1'b0;
    end else begin
      ord_pend_q <= upd_i[0] && upd_i[1] && (upd_idx_i[0] == upd_idx_i[1]);
      ord_idx_q  <= upd_idx_i[1];
      ord_way_q  <= upd_way_i[1];
    end
  end

  AST_LRU_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ord_pend_q |-> (lru_q[ord_idx_q] == ~ord_way_q))
    else $error("same-set recency not port 1 last"); // R6
endmodule

// File: rtl/dcache_miss_ctrl.sv
module dcache_miss_ctrl
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5,
  localparam int unsigned LINE_AW = ADDR_W - OFF_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              load_miss_i,
  input  logic [NUM_PORTS-1:0][LINE_AW-1:0] line_i,
  input  logic                              victim_i,
  output logic                              fill_req_o,
  output logic [ADDR_W-1:0]                 fill_addr_o,
  input  logic                              fill_valid_i,
  output logic                              refill_o,
  output logic [LINE_AW-1:0]                refill_line_o,
  output logic                              refill_way_o
);
  fill_state_e        state_q;
  logic [LINE_AW-1:0] line_q;
  logic               way_q;
  logic               start;

  assign start = (state_q == FILL_IDLE) && (|load_miss_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      line_q  <= '0;
      way_q   <= 1'b0;
    end else if (start) begin
      state_q <= FILL_WAIT;
      line_q  <= load_miss_i[0] ? line_i[0] : line_i[1];  // port 0 first
      way_q   <= victim_i;
    end else if (state_q == FILL_WAIT && fill_valid_i) begin
      state_q <= FILL_IDLE;
    end
  end

  assign fill_req_o    = (state_q == FILL_WAIT);
  assign fill_addr_o   = {line_q, {OFF_W{1'b0}}};
  assign refill_o      = fill_req_o && fill_valid_i;
  assign refill_line_o = line_q;
  assign refill_way_o  = way_q;

  AST_FILL_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_valid_i |=> fill_req_o && $stable(fill_addr_o))
    else $error("refill request dropped or moved"); // R2

  AST_PORT0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_req_o) && $past(load_miss_i[0]) |->
      fill_addr_o[ADDR_W-1:OFF_W] == $past(line_i[0]))
    else $error("port 1 served before port 0"); // R3
endmodule

// File: rtl/dcache_dual.sv
module dcache_dual
  import dcache_pkg::*;
#(
  parameter int unsigned CAP_BYTES  = 4096,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             flush_i,
  input  logic [NUM_PORTS-1:0]             req_i,
  input  logic [NUM_PORTS-1:0]             we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata_o,
  output logic                             stall_o,
  output logic                             fill_req_o,
  output logic [ADDR_W-1:0]                fill_addr_o,
  input  logic                             fill_valid_i,
  input  logic [LINE_W-1:0]                fill_data_i,
  output logic [NUM_PORTS-1:0]             wr_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0] wr_addr_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] wr_data_o
);
  localparam int unsigned SETS    = CAP_BYTES / (LINE_BYTES * NUM_WAYS);
  localparam int unsigned WORDS   = LINE_BYTES / (DATA_W / 8);
  localparam int unsigned BOFF_W  = $clog2(DATA_W / 8);
  localparam int unsigned WOFF_W  = $clog2(WORDS);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W   = $clog2(SETS);
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned LINE_AW = ADDR_W - OFF_W;

  logic [NUM_PORTS-1:0][IDX_W-1:0]    idx;
  logic [NUM_PORTS-1:0][TAG_W-1:0]    tag;
  logic [NUM_PORTS-1:0][WOFF_W-1:0]   woff;
  logic [NUM_PORTS-1:0][LINE_AW-1:0]  line;
  logic [NUM_PORTS-1:0][NUM_WAYS-1:0] hit_way;
  logic [NUM_PORTS-1:0]               hit, hway, load_miss, acc, upd, st_hit;

  logic               refill, refill_way, lru_vic, vic_way, shield;
  logic [LINE_AW-1:0] refill_line;
  logic [IDX_W-1:0]   refill_idx, vic_idx;
  logic [TAG_W-1:0]   refill_tag;

  logic [DATA_W-1:0] data_q [NUM_WAYS][SETS][WORDS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign idx[p]       = addr_i[p][OFF_W +: IDX_W];
    assign tag[p]       = addr_i[p][ADDR_W-1 -: TAG_W];
    assign woff[p]      = addr_i[p][BOFF_W +: WOFF_W];
    assign line[p]      = addr_i[p][ADDR_W-1:OFF_W];
    assign hit[p]       = |hit_way[p];
    assign hway[p]      = hit_way[p][1];
    assign load_miss[p] = req_i[p] & ~we_i[p] & ~hit[p];
    assign acc[p]       = req_i[p] & ~stall_o;
    assign upd[p]       = acc[p] & hit[p];
    assign st_hit[p]    = acc[p] & hit[p] & we_i[p];
    assign wr_o[p]      = acc[p] & we_i[p];
    assign wr_addr_o[p] = addr_i[p];
    assign wr_data_o[p] = wdata_i[p];
    assign rdata_o[p]   = data_q[hway[p]][idx[p]][woff[p]];

    AST_ONE_WAY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_way[p]))
      else $error("line resident in both ways"); // R4
  end

  assign stall_o = |load_miss;

  // a port-0 hit in the missing set counts as already touched
  assign vic_idx = load_miss[0] ? idx[0] : idx[1];
  assign shield  = ~load_miss[0] & req_i[0] & hit[0] & (idx[0] == idx[1]);
  assign vic_way = shield ? ~hway[0] : lru_vic;

  assign refill_idx = refill_line[IDX_W-1:0];
  assign refill_tag = refill_line[LINE_AW-1 -: TAG_W];

  dcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lk_idx_i     (idx),
    .lk_tag_i     (tag),
    .hit_way_o    (hit_way),
    .refill_i     (refill),
    .refill_idx_i (refill_idx),
    .refill_tag_i (refill_tag),
    .refill_way_i (refill_way)
  );

  dcache_lru #(.SETS(SETS)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (upd),
    .upd_idx_i    (idx),
    .upd_way_i    (hway),
    .refill_i     (refill),
    .refill_idx_i (refill_idx),
    .refill_way_i (refill_way),
    .vic_idx_i    (vic_idx),
    .victim_o     (lru_vic)
  );

  dcache_miss_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_miss (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_miss_i   (load_miss),
    .line_i        (line),
    .victim_i      (vic_way),
    .fill_req_o    (fill_req_o),
    .fill_addr_o   (fill_addr_o),
    .fill_valid_i  (fill_valid_i),
    .refill_o      (refill),
    .refill_line_o (refill_line),
    .refill_way_o  (refill_way)
  );

  // refill only happens while stalled, so it never meets a store hit
  always_ff @(posedge clk_i) begin
    if (refill) begin
      for (int w = 0; w < WORDS; w++) begin
        data_q[refill_way][refill_idx][w] <= fill_data_i[w*DATA_W +: DATA_W];
      end
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (st_hit[p]) data_q[hway[p]][idx[p]][woff[p]] <= wdata_i[p];
    end
  end
endmodule

// File: tb/dcache_dual_bench.sv
`timescale 1ns/1ps
module dcache_dual_bench;
  localparam int CAP  = 256;
  localparam int LINE = 16;
  localparam int LW   = LINE * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic [1:0]       req = '0, we = '0;
  logic [1:0][31:0] addr = '0, wdata = '0;
  logic [1:0][31:0] rdata;
  logic             stall;
  logic             fill_req;
  logic [31:0]      fill_addr;
  logic             fill_valid = 1'b0;
  logic [LW-1:0]    fill_data = '0;
  logic [1:0]       wr;
  logic [1:0][31:0] wr_addr, wr_data;

  int checks = 0, failures = 0, fill_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dcache_dual #(.CAP_BYTES(CAP), .LINE_BYTES(LINE)) u_dcache_dual (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .stall_o(stall), .fill_req_o(fill_req), .fill_addr_o(fill_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  function automatic logic [31:0] seed_val(logic [31:0] w);
    return (w * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  logic [31:0] mem_m  [logic [31:0]];
  logic [31:0] gold_m [logic [31:0]];

  function automatic logic [31:0] mem_rd(logic [31:0] w);
    return mem_m.exists(w) ? mem_m[w] : seed_val(w);
  endfunction
  function automatic logic [31:0] gold_rd(logic [31:0] w);
    return gold_m.exists(w) ? gold_m[w] : seed_val(w);
  endfunction

  // next-level memory: applies forwarded writes, answers refills after a delay
  int          lat_cnt = 0;
  bit          busy = 0;
  logic [31:0] base_l = '0;
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) if (wr[p]) mem_m[wr_addr[p] >> 2] = wr_data[p];
    if (fill_valid) begin
      fill_valid <= 1'b0;
    end else if (busy) begin
      if (lat_cnt == 0) begin
        logic [LW-1:0] ln;
        for (int i = 0; i < LINE / 4; i++) ln[i*32 +: 32] = mem_rd((base_l >> 2) + i);
        fill_data  <= ln;
        fill_valid <= 1'b1;
        busy       <= 0;
      end else lat_cnt <= lat_cnt - 1;
    end else if (fill_req) begin
      busy     <= 1;
      lat_cnt  <= 2;
      base_l   <= fill_addr;
      fill_cnt <= fill_cnt + 1;
    end
  end

  // reference tag/valid/recency model, sets = 8, tag = addr[31:7]
  bit          rv [2][8];
  logic [24:0] rt [2][8];
  bit          rl [8];

  task automatic ref_touch(input logic [31:0] a, input bit ld, inout int f);
    int s; int hw; bit v;
    s = int'(a[6:4]);
    hw = -1;
    for (int w = 0; w < 2; w++) if (rv[w][s] && rt[w][s] == a[31:7]) hw = w;
    if (hw >= 0) rl[s] = (hw == 0);
    else if (ld) begin
      v = rl[s];
      rv[v][s] = 1; rt[v][s] = a[31:7]; rl[s] = !v;
      f++;
    end
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int t, int s, int w);
    return 32'(t * 128 + s * 16 + w * 4);
  endfunction

  task automatic acc(input logic r0, input logic w0, input logic [31:0] a0, input logic [31:0] d0,
                     input logic r1, input logic w1, input logic [31:0] a1, input logic [31:0] d1,
                     input string rq);
    logic [31:0] e0, e1;
    int pf, f0, st;
    e0 = gold_rd(a0 >> 2); e1 = gold_rd(a1 >> 2);
    pf = 0;
    if (r0) ref_touch(a0, !w0, pf);
    if (r1) ref_touch(a1, !w1, pf);
    f0 = fill_cnt; st = 0;
    @(negedge clk);
    req = {r1, r0}; we = {w1, w0}; addr = {a1, a0}; wdata = {d1, d0};
    #1;
    while (stall) begin @(negedge clk); #1; st++; end
    if (r0 && !w0) chk(rdata[0] == e0, rq, "port0 load", rdata[0], e0);
    if (r1 && !w1) chk(rdata[1] == e1, rq, "port1 load", rdata[1], e1);
    if (pf == 0) chk(st == 0, "R1", "stall cycles on hit", st, 0);
    @(posedge clk); #1;
    req = '0;
    chk(fill_cnt - f0 == pf, rq, "refill count", fill_cnt - f0, pf);
    if (r0 && w0) gold_m[a0 >> 2] = d0;
    if (r1 && w1) gold_m[a1 >> 2] = d1;
    if (r0 && w0) chk(mem_rd(a0 >> 2) == gold_rd(a0 >> 2), "R7", "port0 forwarded store",
                      mem_rd(a0 >> 2), gold_rd(a0 >> 2));
    if (r1 && w1) chk(mem_rd(a1 >> 2) == gold_rd(a1 >> 2), "R7", "port1 forwarded store",
                      mem_rd(a1 >> 2), gold_rd(a1 >> 2));
  endtask

  task automatic ld1(input logic [31:0] a, input string rq);
    acc(1, 0, a, 0, 0, 0, 0, 0, rq);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int s = 0; s < 8; s++) begin rl[s] = 0; rv[0][s] = 0; rv[1][s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R11 reset state
    chk(stall == 1'b0, "R11", "stall after reset", 32'(stall), 0);
    chk(fill_req == 1'b0, "R11", "refill request after reset", 32'(fill_req), 0);
    chk(wr == 2'b00, "R11", "write strobes after reset", 32'(wr), 0);

    // R2: one refill per set
    for (int s = 0; s < 8; s++) ld1(mk(1, s, s % 4), "R2");
    // R1: dual hits across every word
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++)
        acc(1, 0, mk(1, s, w), 0, 1, 0, mk(1, (s + 3) % 8, 3 - w), 0, "R1");

    // R3: dual miss on different lines, then R4 coexistence in one set
    acc(1, 0, mk(10, 5, 0), 0, 1, 0, mk(11, 5, 1), 0, "R3");
    acc(1, 0, mk(11, 5, 2), 0, 1, 0, mk(10, 5, 3), 0, "R4");
    // R5: third tag evicts least recent, then the evicted line misses
    ld1(mk(12, 5, 2), "R5");
    ld1(mk(10, 5, 0), "R5");
    ld1(mk(11, 5, 1), "R5");

    // R6: same-set dual access ordering
    ld1(mk(20, 6, 0), "R6");
    ld1(mk(21, 6, 0), "R6");
    acc(1, 0, mk(21, 6, 1), 0, 1, 0, mk(20, 6, 1), 0, "R6");
    ld1(mk(22, 6, 0), "R6");
    ld1(mk(20, 6, 2), "R6");
    ld1(mk(21, 6, 3), "R6");
    // R6: port 1 miss must not evict the line port 0 hits
    ld1(mk(23, 4, 0), "R6");
    ld1(mk(24, 4, 0), "R6");
    ld1(mk(23, 4, 1), "R6");
    acc(1, 0, mk(24, 4, 2), 0, 1, 0, mk(25, 4, 0), 0, "R6");

    // R3: both ports miss the same line
    acc(1, 0, mk(30, 1, 0), 0, 1, 0, mk(30, 1, 3), 0, "R3");
    // R7: store hit then read back on both ports
    acc(1, 1, mk(30, 1, 2), 32'hCAFE0001, 0, 0, 0, 0, "R7");
    acc(1, 0, mk(30, 1, 2), 0, 1, 0, mk(30, 1, 2), 0, "R7");
    // R8: store miss, no refill, later load fetches stored value
    acc(0, 0, 0, 0, 1, 1, mk(40, 3, 1), 32'hBEEF0002, "R8");
    ld1(mk(40, 3, 1), "R8");
    // R9: load sees pre-store value; double store keeps port 1
    acc(1, 1, mk(30, 1, 0), 32'h11110003, 1, 0, mk(30, 1, 0), 0, "R9");
    acc(1, 1, mk(30, 1, 3), 32'h22220004, 1, 1, mk(30, 1, 3), 32'h33330005, "R9");
    acc(1, 0, mk(30, 1, 3), 0, 1, 0, mk(30, 1, 0), 0, "R9");

    // R10: flush drops everything
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int s = 0; s < 8; s++) begin rv[0][s] = 0; rv[1][s] = 0; end
    ld1(mk(30, 1, 0), "R10");
    ld1(mk(1, 2, 0), "R10");

    // near-exhaustive mixed sweep over 8 tags x 8 sets
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a0, a1;
      logic r0, r1, w0, w1;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a0 = mk(int'(lcg[10:8]), int'(lcg[13:11]), int'(lcg[15:14]));
      a1 = mk(int'(lcg[18:16]), (lcg[31]) ? int'(lcg[13:11]) : int'(lcg[21:19]), int'(lcg[23:22]));
      r0 = lcg[24] | lcg[25]; r1 = lcg[26] | lcg[27];
      w0 = lcg[28] & lcg[29]; w1 = lcg[30] & lcg[29];
      acc(r0, w0, a0, lcg ^ 32'hA5A5A5A5, r1, w1, a1, ~lcg, "R5");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule